// File: doc/BRIEF.md
# Sound-Generator Register Stream Player

This block plays back a recorded stream of register settings for a programmable sound generator. The recording is held in a local byte store organised as a ring of sector buffers, 512 bytes each. Every sector holds 32 frames of 16 bytes. On each replay tick (about 50 Hz, divided down from the system clock) the player takes one frame and writes it into the generator's sixteen 8-bit registers. The writes go through a two-phase port: an address strobe cycle that carries the register number on the shared bus, then a data strobe cycle that carries the value.

Software or another agent loads a frame budget, fills sectors through a byte write port and marks each filled sector ready with a one-bit pulse. The player reports which sector it is reading so the filler can stay clear of it. A consumed sector loses its ready mark. When the budget is spent, or the sector under the read pointer is not ready, a tick silences the generator instead of playing. After reset the generator is silenced once before any playback.

Top module: `psg_replay_engine`

## Requirements
- R1: After reset, before any playback, the block writes 0x00 to generator registers 0 to 15 in ascending order. While reset is held, both strobes are low and the bus is 0x00.
- R2: Each register write takes two consecutive cycles. In the first cycle `genAddrStb` is high and `genBus[3:0]` holds the register number (upper bits zero). In the next cycle `genDataStb` is high and `genBus` holds the value. The two strobes are never high together.
- R3: Playing a frame writes frame bytes 0 to 12 to registers 0 to 12 in ascending order. Frame n of sector s starts at fill address s*512 + n*16.
- R4: Frame byte 13 is written to register 13 only if it is not 0xFF. If it is 0xFF the frame ends after register 12. Frame bytes 14 and 15 are never written.
- R5: After each played frame the read position moves on by 16 bytes. After frame 31 of a sector it moves to frame 0 of the next sector, and from sector NUM_BUF-1 it goes back to sector 0. `readSector` shows the sector being read.
- R6: A `frameLoad` pulse sets the remaining-frame count to `frameTotal`. On a tick with a nonzero count and a ready sector, the count drops by one and one frame is played. On a tick with a zero count, 0x00 is written to all 16 registers in ascending order.
- R7: Bit i of `sectorReady` marks sector i ready. Playing the last frame of a sector clears that sector's mark. On a tick where the current sector is not ready, all 16 registers are written with 0x00, and the frame count and read position stay unchanged.
- R8: Replay ticks repeat every 2*(TICK_LIMIT+1) clock cycles. A tick that finds the block idle starts its write sequence one cycle after the internal tick pulse.
- R9: A tick that arrives while a sequence is in progress is held in a single pending flag. The next sequence's first address strobe then comes two cycles after the last data strobe of the current sequence.
- R10: `busy` is high from the first cycle of a sequence through its last data strobe, and low between sequences. The start-up sequence is 33 cycles, a silencing sequence 32 cycles, and a played frame 26 or 28 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fillWe | input | 1 | Byte write enable into the sector store |
| fillAddr | input | SEC_W+9 | Store byte address: sector, frame and byte fields |
| fillData | input | 8 | Byte to store |
| sectorReady | input | NUM_BUF | One-cycle pulse per bit; marks sector i ready |
| frameLoad | input | 1 | Loads the remaining-frame count |
| frameTotal | input | CNT_W | Value loaded by frameLoad |
| genAddrStb | output | 1 | Register-number phase of a generator write |
| genDataStb | output | 1 | Value phase of a generator write |
| genBus | output | 8 | Register number or value, depending on the phase |
| busy | output | 1 | A write sequence is in progress |
| readSector | output | SEC_W | Sector currently being read |

## Verification
The store is filled with random bytes, with register 13's byte forced to 0xFF in every third frame. This separates the 13-write frame from the 14-write frame and shows that bytes 14 and 15 never reach the bus. The budget is loaded in three patterns: a single frame, a run that crosses a sector boundary, and a run that meets a sector that has been consumed and not refilled. These tell apart silencing for an empty count from a stall that must keep the count and the position. The stall is then released by refilling. Cycle gaps between sequence starts separate a held tick, served straight after the start-up silencing, from ticks that arrive while the block is idle.

// File: rtl/psg_replay_pkg.sv
package psg_replay_pkg;
  localparam int FRAME_BYTES    = 16;
  localparam int SECTOR_BYTES   = 512;
  localparam int GEN_REGS       = 16;
  localparam int ENV_REG        = 13;
  localparam int LAST_FIXED_REG = 12;
  localparam int REG_W          = $clog2(GEN_REGS);
  localparam int BYTE_W         = $clog2(FRAME_BYTES);
  localparam int SLOT_W         = $clog2(SECTOR_BYTES / FRAME_BYTES);
  localparam logic [7:0] KEEP_ENV_CODE = 8'hFF;

  typedef enum logic [1:0] {
    SQ_BOOT,
    SQ_IDLE,
    SQ_ADDR,
    SQ_DATA
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeFrame;  // consume one frame from the budget
    logic frameDone;  // move the read position to the next frame
    logic addrPhase;  // bus carries the register number
    logic dataPhase;  // bus carries the register value
    logic muteData;   // value phase drives zero
  } seqCmd_t;
endpackage

// File: rtl/psg_replay_tick.sv
module psg_replay_tick #(
  parameter int unsigned TICK_LIMIT = 39999
) (
  input  logic clk,
  input  logic rst_n,
  output logic tickPulse
);
  localparam int CNT_W = $clog2(TICK_LIMIT + 2);

  logic [CNT_W-1:0] divCnt;
  logic             rateLevel;

  // the rate signal toggles at every terminal count; a tick marks its rise
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt    <= '0;
      rateLevel <= 1'b0;
      tickPulse <= 1'b0;
    end else begin
      tickPulse <= 1'b0;
      if (divCnt == CNT_W'(TICK_LIMIT)) begin
        divCnt    <= '0;
        rateLevel <= ~rateLevel;
        tickPulse <= ~rateLevel;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/psg_replay_ctrl.sv
module psg_replay_ctrl
  import psg_replay_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickPulse,
  input  logic             framesZero,
  input  logic             sectorValid,
  input  logic             envSkip,
  output seqCmd_t          cmd,
  output logic [REG_W-1:0] regIdx,
  output logic             busy
);
  seqState_t state;
  logic      muteMode;
  logic      pending;
  logic      lastWrite;
  logic      beginSvc;
  logic      playOk;
  logic      endReg;

  always_comb begin
    playOk   = !framesZero && sectorValid;
    beginSvc = (state == SQ_IDLE) && (tickPulse || pending);
    if (muteMode) begin
      endReg = (regIdx == REG_W'(GEN_REGS - 1));
    end else begin
      endReg = (regIdx == REG_W'(ENV_REG)) ||
               ((regIdx == REG_W'(LAST_FIXED_REG)) && envSkip);
    end
    lastWrite     = endReg && (state == SQ_DATA);
    cmd.takeFrame = beginSvc && playOk;
    cmd.frameDone = lastWrite && !muteMode;
    cmd.addrPhase = (state == SQ_ADDR);
    cmd.dataPhase = (state == SQ_DATA);
    cmd.muteData  = muteMode;
    busy          = (state != SQ_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_BOOT;
      regIdx   <= '0;
      muteMode <= 1'b1;
      pending  <= 1'b0;
    end else begin
      case (state)
        SQ_BOOT: begin
          state    <= SQ_ADDR;
          regIdx   <= '0;
          muteMode <= 1'b1;
        end
        SQ_IDLE: begin
          if (beginSvc) begin
            state    <= SQ_ADDR;
            regIdx   <= '0;
            muteMode <= !playOk;
          end
        end
        SQ_ADDR: state <= SQ_DATA;
        SQ_DATA: begin
          if (lastWrite) begin
            state <= SQ_IDLE;
          end else begin
            state  <= SQ_ADDR;
            regIdx <= regIdx + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
      // one held tick at most; it is consumed on the idle cycle
      if (state == SQ_IDLE) begin
        pending <= 1'b0;
      end else if (tickPulse) begin
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/psg_replay_dp.sv
module psg_replay_dp
  import psg_replay_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int CNT_W   = 16,
  localparam int SEC_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int ADDR_W = SEC_W + SLOT_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fillWe,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [7:0]        fillData,
  input  logic [NUM_BUF-1:0] sectorReady,
  input  logic              frameLoad,
  input  logic [CNT_W-1:0]  frameTotal,
  input  seqCmd_t           cmd,
  input  logic [REG_W-1:0]  regIdx,
  output logic [7:0]        genBus,
  output logic              framesZero,
  output logic              sectorValid,
  output logic              envSkip,
  output logic [SEC_W-1:0]  readSector
);
  localparam int MEM_BYTES = NUM_BUF * SECTOR_BYTES;

  logic [7:0]         store [MEM_BYTES];
  logic [SLOT_W-1:0]  slot;
  logic [SEC_W-1:0]   sector;
  logic [NUM_BUF-1:0] readyMask;
  logic [NUM_BUF-1:0] doneMask;
  logic [CNT_W-1:0]   framesLeft;
  logic [ADDR_W-1:0]  rdAddr;
  logic [ADDR_W-1:0]  envAddr;
  logic [7:0]         curByte;
  logic               sectorEnd;

  always_ff @(posedge clk) begin
    if (fillWe) store[fillAddr] <= fillData;
  end

  always_comb begin
    rdAddr      = {sector, slot, BYTE_W'(regIdx)};
    envAddr     = {sector, slot, BYTE_W'(ENV_REG)};
    curByte     = store[rdAddr];
    envSkip     = (store[envAddr] == KEEP_ENV_CODE);
    sectorValid = readyMask[sector];
    framesZero  = (framesLeft == '0);
    readSector  = sector;
    sectorEnd   = cmd.frameDone && (slot == '1);
    doneMask    = sectorEnd ? (NUM_BUF'(1) << sector) : '0;
    if (cmd.addrPhase) begin
      genBus = {{(8 - REG_W){1'b0}}, regIdx};
    end else if (cmd.dataPhase && !cmd.muteData) begin
      genBus = curByte;
    end else begin
      genBus = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot       <= '0;
      sector     <= '0;
      readyMask  <= '0;
      framesLeft <= '0;
    end else begin
      if (frameLoad) begin
        framesLeft <= frameTotal;
      end else if (cmd.takeFrame) begin
        framesLeft <= framesLeft - 1'b1;
      end
      readyMask <= (readyMask & ~doneMask) | sectorReady;
      if (cmd.frameDone) begin
        slot <= slot + 1'b1;
        if (sectorEnd) begin
          sector <= (sector == SEC_W'(NUM_BUF - 1)) ? '0 : sector + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psg_replay_engine.sv
module psg_replay_engine
  import psg_replay_pkg::*;
#(
  parameter int unsigned TICK_LIMIT = 39999,
  parameter int NUM_BUF   = 4,
  parameter int CNT_W     = 16,
  localparam int SEC_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int FILL_W   = SEC_W + SLOT_W + BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fillWe,
  input  logic [FILL_W-1:0]  fillAddr,
  input  logic [7:0]         fillData,
  input  logic [NUM_BUF-1:0] sectorReady,
  input  logic               frameLoad,
  input  logic [CNT_W-1:0]   frameTotal,
  output logic               genAddrStb,
  output logic               genDataStb,
  output logic [7:0]         genBus,
  output logic               busy,
  output logic [SEC_W-1:0]   readSector
);
  logic             tickPulse;
  logic             framesZero;
  logic             sectorValid;
  logic             envSkip;
  logic [REG_W-1:0] regIdx;
  seqCmd_t          cmd;

  psg_replay_tick #(.TICK_LIMIT(TICK_LIMIT)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .tickPulse (tickPulse)
  );

  psg_replay_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tickPulse   (tickPulse),
    .framesZero  (framesZero),
    .sectorValid (sectorValid),
    .envSkip     (envSkip),
    .cmd         (cmd),
    .regIdx      (regIdx),
    .busy        (busy)
  );

  psg_replay_dp #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .fillWe      (fillWe),
    .fillAddr    (fillAddr),
    .fillData    (fillData),
    .sectorReady (sectorReady),
    .frameLoad   (frameLoad),
    .frameTotal  (frameTotal),
    .cmd         (cmd),
    .regIdx      (regIdx),
    .genBus      (genBus),
    .framesZero  (framesZero),
    .sectorValid (sectorValid),
    .envSkip     (envSkip),
    .readSector  (readSector)
  );

  assign genAddrStb = cmd.addrPhase;
  assign genDataStb = cmd.dataPhase;
endmodule

// File: rtl/psg_replay_chk.sv
module psg_replay_chk #(
  parameter int NUM_BUF = 4,
  parameter int SEC_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             genAddrStb,
  input logic             genDataStb,
  input logic [7:0]       genBus,
  input logic             busy,
  input logic [SEC_W-1:0] readSector
);
  logic [7:0]       lastAddr;
  logic [SEC_W-1:0] prevSec;
  logic [SEC_W-1:0] stepSec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastAddr <= 8'h00;
      prevSec  <= '0;
    end else begin
      if (genAddrStb) lastAddr <= genBus;
      prevSec <= readSector;
    end
  end

  always_comb stepSec = (prevSec == SEC_W'(NUM_BUF - 1)) ? '0 : prevSec + 1'b1;

  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(genAddrStb && genDataStb));

  a_r2_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    genAddrStb |=> genDataStb);

  a_r2_data_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    genDataStb |-> $past(genAddrStb));

  a_r2_reg_range: assert property (@(posedge clk) disable iff (!rst_n)
    genAddrStb |-> (genBus < 8'd16));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (genAddrStb && genBus != 8'h00) |-> (genBus == lastAddr + 8'd1));

  a_r5_sector_step: assert property (@(posedge clk) disable iff (!rst_n)
    (readSector != prevSec) |-> (readSector == stepSec));

  a_r10_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (genAddrStb || genDataStb) |-> busy);
endmodule

bind psg_replay_engine psg_replay_chk #(.NUM_BUF(NUM_BUF), .SEC_W(SEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .genAddrStb (genAddrStb),
  .genDataStb (genDataStb),
  .genBus     (genBus),
  .busy       (busy),
  .readSector (readSector)
);

// File: tb/test_psg_replay_engine.sv
module test_psg_replay_engine;
  localparam int NB       = 2;
  localparam int LIM      = 29;
  localparam int CW       = 16;
  localparam int SW       = 1;
  localparam int FW       = SW + 9;
  localparam int PERIOD_T = 2 * (LIM + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fillWe = 1'b0;
  logic [FW-1:0] fillAddr = '0;
  logic [7:0]    fillData = 8'h00;
  logic [NB-1:0] sectorReady = '0;
  logic          frameLoad = 1'b0;
  logic [CW-1:0] frameTotal = '0;
  logic          genAddrStb, genDataStb, busy;
  logic [7:0]    genBus;
  logic [SW-1:0] readSector;

  always #4 clk = ~clk;

  psg_replay_engine #(.TICK_LIMIT(LIM), .NUM_BUF(NB), .CNT_W(CW)) i_psg_replay_engine (
    .clk(clk), .rst_n(rst_n), .fillWe(fillWe), .fillAddr(fillAddr), .fillData(fillData),
    .sectorReady(sectorReady), .frameLoad(frameLoad), .frameTotal(frameTotal),
    .genAddrStb(genAddrStb), .genDataStb(genDataStb), .genBus(genBus),
    .busy(busy), .readSector(readSector)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;
  byte unsigned refMem [NB*512];
  int mFrames = 0, mSlot = 0, mSec = 0;
  bit mValid [NB];
  int expA [16], expD [16];
  string expTag = "R1";
  int expN = 0, expRd = 0;
  int svcCount = 0, cyc = 0, busyRun = 0, svcLen = 0, lastStart = 0, firstStart = 0;
  int playCount = 0, lastA = 0;
  bit stallSeen = 1'b0, prevAddr = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected writes of the sequence that is starting, from the model state
  function automatic void buildService();
    expN = 0;
    expRd = 0;
    if (svcCount == 0 || mFrames == 0 || !mValid[mSec]) begin
      expTag = (svcCount == 0) ? "R1" : (mFrames == 0) ? "R6" : "R7";
      if (svcCount != 0 && mFrames != 0) stallSeen = 1'b1;
      for (int i = 0; i < 16; i++) begin
        expA[i] = i;
        expD[i] = 0;
      end
      expN = 16;
    end else begin
      int base = mSec * 512 + mSlot * 16;
      expTag = "R3";
      for (int i = 0; i < 13; i++) begin
        expA[i] = i;
        expD[i] = refMem[base + i];
      end
      expN = 13;
      if (refMem[base + 13] != 8'hFF) begin
        expA[13] = 13;
        expD[13] = refMem[base + 13];
        expN = 14;
        expTag = "R4";
      end
      mFrames--;
      playCount++;
      mSlot++;
      if (mSlot == 32) begin
        mSlot = 0;
        mValid[mSec] = 1'b0;
        mSec = (mSec + 1) % NB;
      end
    end
    svcLen = 2 * expN + ((svcCount == 0) ? 1 : 0);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (busy) begin
        busyRun++;
      end else if (busyRun != 0) begin
        chk(busyRun == svcLen, "R10", "busy length", busyRun, svcLen);
        chk(expRd == expN, expTag, "writes in sequence", expRd, expN);
        busyRun = 0;
      end
      if (genAddrStb) begin
        if (genBus == 8'h00) begin
          chk(expRd == expN, expTag, "previous sequence complete", expRd, expN);
          if (svcCount == 0) firstStart = cyc;
          if (svcCount == 1) chk(cyc - firstStart == 33, "R9", "held tick start gap", cyc - firstStart, 33);
          if (svcCount >= 3) chk(cyc - lastStart == PERIOD_T, "R8", "tick period", cyc - lastStart, PERIOD_T);
          chk(int'(readSector) == mSec, "R5", "read sector", int'(readSector), mSec);
          lastStart = cyc;
          buildService();
          svcCount++;
        end
        lastA = genBus;
      end
      if (genDataStb) begin
        chk(prevAddr, "R2", "data strobe after address strobe", 0, 1);
        if (expRd < expN) begin
          chk(lastA == expA[expRd] && int'(genBus) == expD[expRd], expTag, "write reg*256+value",
              lastA * 256 + int'(genBus), expA[expRd] * 256 + expD[expRd]);
        end else begin
          chk(1'b0, (expTag == "R3") ? "R4" : expTag, "extra write reg", lastA, -1);
        end
        expRd++;
      end
      prevAddr = genAddrStb;
    end
  end

  task automatic skipSvc(int n);
    int t = svcCount + n;
    while (svcCount < t) @(negedge clk);
  endtask

  task automatic afterStart();
    skipSvc(1);
    @(negedge clk);
  endtask

  task automatic fillSector(int s);
    for (int i = 0; i < 512; i++) begin
      byte unsigned v = 8'($urandom());
      if ((i % 16) == 13 && ((i / 16) % 3) == 0) v = 8'hFF;
      @(negedge clk);
      fillWe = 1'b1;
      fillAddr = FW'(s * 512 + i);
      fillData = v;
      refMem[s * 512 + i] = v;
    end
    @(negedge clk);
    fillWe = 1'b0;
  endtask

  task automatic markReady(logic [NB-1:0] m);
    afterStart();
    sectorReady = m;
    for (int i = 0; i < NB; i++) if (m[i]) mValid[i] = 1'b1;
    @(negedge clk);
    sectorReady = '0;
  endtask

  task automatic loadBudget(int n);
    afterStart();
    frameLoad = 1'b1;
    frameTotal = CW'(n);
    mFrames = n;
    @(negedge clk);
    frameLoad = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1357_2468));
    for (int i = 0; i < NB; i++) mValid[i] = 1'b0;
    repeat (4) @(negedge clk);
    chk(!genAddrStb && !genDataStb, "R1", "strobes in reset", int'(genAddrStb) + int'(genDataStb), 0);
    chk(genBus == 8'h00, "R1", "bus in reset", int'(genBus), 0);
    chk(readSector == '0, "R5", "sector in reset", int'(readSector), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    fillSector(0);
    fillSector(1);
    markReady(2'b11);
    loadBudget(1);       // single frame, then silence
    skipSvc(3);
    loadBudget(39);      // crosses from sector 0 into sector 1
    while (mFrames != 0) @(negedge clk);
    skipSvc(2);
    loadBudget(30);      // runs into the consumed sector 0 and stalls
    while (!stallSeen) @(negedge clk);
    skipSvc(2);
    fillSector(0);
    markReady(2'b01);
    while (mFrames != 0) @(negedge clk);
    skipSvc(2);
    chk(playCount == 70, "R6", "frames played", playCount, 70);
    chk(int'(readSector) == 0, "R5", "sector after refill run", int'(readSector), 0);
    chk(mSlot == 6, "R7", "frames after stall", mSlot, 6);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", svcCount, -1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule